// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether a conditional instruction or branch goes ahead. It takes the four stored status flags and a 4-bit condition selector. The flags are negative (N), zero (Z), carry (C) and overflow (V). It returns one pass bit that the issue logic uses to execute or squash the instruction. The block is purely combinational, so pass follows its inputs in the same cycle with no clock.

There are three kinds of condition. Single-flag tests look at one flag, either set or clear. Unsigned magnitude tests combine carry with zero. Signed magnitude tests combine the sign with overflow through N XOR V, and one of them also uses zero. The selector codes come in pairs. An odd code passes exactly when the even code just below it fails. The last pair holds an unconditional pass and a reserved code that never passes.

Top module: `cond_eval`

## Requirements
- R1: Code 4'b0000 passes when Z=1; code 4'b0001 passes when Z=0.
- R2: Code 4'b0010 passes when C=1; code 4'b0011 passes when C=0.
- R3: Code 4'b0100 passes when N=1; code 4'b0101 passes when N=0.
- R4: Code 4'b0110 passes when V=1; code 4'b0111 passes when V=0.
- R5: Code 4'b1000 (unsigned higher) passes when C=1 and Z=0; code 4'b1001 (unsigned lower or same) passes when C=0 or Z=1.
- R6: Code 4'b1010 (signed greater or equal) passes when N equals V; code 4'b1011 (signed less) passes when N differs from V.
- R7: Code 4'b1100 (signed greater) passes when Z=0 and N equals V; code 4'b1101 (signed less or equal) passes when Z=1 or N differs from V.
- R8: Code 4'b1110 passes for every flag combination.
- R9: Code 4'b1111 is reserved and gives pass=0 for every flag combination.
- R10: For every even code from 4'b0000 to 4'b1100 and any flags, the odd code one above gives the inverse pass value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| flag_n | input | 1 | Stored negative flag |
| flag_z | input | 1 | Stored zero flag |
| flag_c | input | 1 | Stored carry flag |
| flag_v | input | 1 | Stored overflow flag |
| cond_code | input | 4 | Condition selector |
| cond_pass | output | 1 | 1 when the selected condition holds |

## Verification
Assertions inside the RTL watch the output whenever an input changes. They check the equal, unsigned-higher, signed-greater-or-equal, signed-greater, always and reserved codes against the flags directly. The bench covers the rest. It sweeps all 256 combinations of code and flags and adds seeded random vectors. It also compares each even/odd code pair under the same flags, which shows that the inverse pairing holds. No single-vector property can show that.

// File: rtl/cond_eval_pkg.sv
// Package: shared widths and condition selector names for the evaluator.
// Assumes a 4-bit selector whose top three bits pick a base predicate and
// whose bottom bit inverts it.
package cond_eval_pkg;

    localparam int CODE_W   = 4;
    localparam int BASE_W   = CODE_W - 1;
    localparam int NUM_BASE = 2 ** BASE_W;

    typedef enum logic [CODE_W-1:0] {
        CND_ZSET  = 4'b0000,
        CND_ZCLR  = 4'b0001,
        CND_CSET  = 4'b0010,
        CND_CCLR  = 4'b0011,
        CND_NSET  = 4'b0100,
        CND_NCLR  = 4'b0101,
        CND_VSET  = 4'b0110,
        CND_VCLR  = 4'b0111,
        CND_UHI   = 4'b1000,
        CND_ULS   = 4'b1001,
        CND_SGE   = 4'b1010,
        CND_SLT   = 4'b1011,
        CND_SGT   = 4'b1100,
        CND_SLE   = 4'b1101,
        CND_ALWAYS = 4'b1110,
        CND_RSVD  = 4'b1111
    } cond_sel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flag_set_t;

endpackage

// File: rtl/cond_base_terms.sv
// Module: cond_base_terms
// Computes the eight base predicates, one per even selector code, from
// the status flags. Slot 7 is the unconditional term. Purely combinational;
// assumes the flags are already stable for the cycle.
module cond_base_terms
    import cond_eval_pkg::*;
(
    input  flag_set_t             flags,
    output logic [NUM_BASE-1:0]   term
);

    logic sign_match;

    // Signed relations agree when sign and overflow are equal.
    always_comb sign_match = ~(flags.n ^ flags.v);

    // One predicate per base slot, indexed by selector bits [3:1].
    always_comb begin
        term    = '0;
        term[0] = flags.z;
        term[1] = flags.c;
        term[2] = flags.n;
        term[3] = flags.v;
        term[4] = flags.c & ~flags.z;
        term[5] = sign_match;
        term[6] = ~flags.z & sign_match;
        term[7] = 1'b1;
    end

    // R5/R6 guard: the combined terms follow their defining flags.
    always_comb begin
        p_uhi_r5: assert (term[4] == (flags.c && !flags.z));
        p_sge_r6: assert (term[5] == (flags.n == flags.v));
    end

endmodule

// File: rtl/cond_sense_select.sv
// Module: cond_sense_select
// Picks one base predicate with a one-hot decode of the selector's upper
// bits and applies the inversion bit. Assumes slot NUM_BASE-1 is the
// always-true term, so its inverted code yields 0 (the reserved code).
module cond_sense_select
    import cond_eval_pkg::*;
(
    input  logic [NUM_BASE-1:0] term,
    input  logic [BASE_W-1:0]   base_sel,
    input  logic                invert,
    output logic                pass
);

    logic [NUM_BASE-1:0] hit;
    logic                raw;

    // One gated term per slot; only the selected slot can be nonzero.
    for (genvar gi = 0; gi < NUM_BASE; gi++) begin : g_slot
        always_comb hit[gi] = term[gi] & (base_sel == BASE_W'(gi));
    end

    // Merge the gated slots and apply the sense bit.
    always_comb begin
        raw  = |hit;
        pass = raw ^ invert;
    end

    // R10 guard: at most one slot is ever enabled.
    always_comb begin
        p_onehot_r10: assert ($onehot0(hit));
    end

endmodule

// File: rtl/cond_eval.sv
// Module: cond_eval (top)
// Condition code evaluator: the four status flags and a 4-bit selector
// give one pass bit. Combinational with no clock or reset. Assumes the
// flags come from an external flag register that is valid this cycle.
module cond_eval
    import cond_eval_pkg::*;
(
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_v,
    input  logic [CODE_W-1:0] cond_code,
    output logic              cond_pass
);

    flag_set_t             flags;
    logic [NUM_BASE-1:0]   term;
    cond_sel_e             sel;

    // Bundle the flag pins and name the selector.
    always_comb begin
        flags.n = flag_n;
        flags.z = flag_z;
        flags.c = flag_c;
        flags.v = flag_v;
        sel     = cond_sel_e'(cond_code);
    end

    cond_base_terms u_terms (
        .flags (flags),
        .term  (term)
    );

    cond_sense_select u_select (
        .term     (term),
        .base_sel (cond_code[CODE_W-1:1]),
        .invert   (cond_code[0]),
        .pass     (cond_pass)
    );

    // Port-level checks of selected conditions against the flag pins.
    always_comb begin
        if (sel == CND_ZSET)   p_zset_r1:   assert (cond_pass == flag_z);
        if (sel == CND_SGT)    p_sgt_r7:    assert (cond_pass == (!flag_z && (flag_n == flag_v)));
        if (sel == CND_ALWAYS) p_always_r8: assert (cond_pass);
        if (sel == CND_RSVD)   p_rsvd_r9:   assert (!cond_pass);
    end

endmodule

// File: tb/cond_eval_bench.sv
// Bench: exhaustive sweep, pair-inversion checks and seeded random vectors
// against a bench-side model of the condition table.
module cond_eval_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic n, z, c, v;
    logic [3:0] code;
    logic pass;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cond_eval u_cond_eval (
        .flag_n    (n),
        .flag_z    (z),
        .flag_c    (c),
        .flag_v    (v),
        .cond_code (code),
        .cond_pass (pass)
    );

    function automatic logic model(input logic [3:0] k, input logic fn,
                                   input logic fz, input logic fc, input logic fv);
        case (k)
            4'b0000: return fz;
            4'b0001: return !fz;
            4'b0010: return fc;
            4'b0011: return !fc;
            4'b0100: return fn;
            4'b0101: return !fn;
            4'b0110: return fv;
            4'b0111: return !fv;
            4'b1000: return fc && !fz;
            4'b1001: return !fc || fz;
            4'b1010: return fn == fv;
            4'b1011: return fn != fv;
            4'b1100: return !fz && (fn == fv);
            4'b1101: return fz || (fn != fv);
            4'b1110: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] k);
        case (k[3:1])
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return k[0] ? "R9" : "R8";
        endcase
    endfunction

    task automatic apply(input logic [3:0] k, input logic [3:0] f);
        @(negedge clk);
        code = k;
        {n, z, c, v} = f;
        #1;
    endtask

    task automatic check_vec(input logic [3:0] k, input logic [3:0] f);
        logic exp;
        apply(k, f);
        exp = model(k, f[3], f[2], f[1], f[0]);
        checks++;
        if (pass !== exp) begin
            errors++;
            $display("FAIL %s code=%b nzcv=%b actual=%b expected=%b",
                     tag(k), k, f, pass, exp);
        end
    endtask

    initial begin
        code = 4'b0000;
        {n, z, c, v} = 4'b0000;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset-time vector, code 0000 with Z=0 must not pass.
        checks++;
        if (pass !== 1'b0) begin
            errors++;
            $display("FAIL R1 initial actual=%b expected=0", pass);
        end
        rst_n = 1'b1;

        // Exhaustive sweep covers R1 through R9.
        for (int k = 0; k < 16; k++)
            for (int f = 0; f < 16; f++)
                check_vec(4'(k), 4'(f));

        // R10: odd code gives the inverse of the even code below it.
        for (int k = 0; k < 14; k += 2) begin
            for (int f = 0; f < 16; f++) begin
                logic even_p, odd_p;
                apply(4'(k), 4'(f));
                even_p = pass;
                apply(4'(k + 1), 4'(f));
                odd_p = pass;
                checks++;
                if (odd_p !== !even_p) begin
                    errors++;
                    $display("FAIL R10 code=%0d nzcv=%b actual=%b expected=%b",
                             k + 1, 4'(f), odd_p, !even_p);
                end
            end
        end

        // Directed corners: R5 C=1,Z=1 fails; R7 Z=1 with N==V fails.
        check_vec(4'b1000, 4'b0110);
        check_vec(4'b1100, 4'b0100);
        check_vec(4'b1101, 4'b1001);

        // Seeded random vectors across all requirements.
        void'($urandom(32'd20240611));
        for (int i = 0; i < 600; i++)
            check_vec(4'($urandom), 4'($urandom));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule